// File: doc/BRIEF.md
# System Clock Mode Controller

This block keeps the processor's clock-mode register and turns two oscillator tick streams into the internal clock enable. The main oscillator is fast and the sub oscillator is slow. Everything runs on one fast system clock. The oscillators come in as single-cycle tick pulses, and the internal clock goes out as single-cycle enable pulses. There are three run modes:

- fast: main ticks divided by 2
- medium: main ticks divided by 8
- slow: sub ticks divided by 2

A register write can change the mode. It is accepted only if it follows a fixed set of allowed steps. Any other write leaves the register as it was and raises a sticky error flag.

The block also sequences the halt (wait) and deep-sleep (stop) states, with a plain wake input. In wait, the CPU clock enable stops, the timer enable keeps running, and the oscillators keep running. In stop, both oscillators are off. When stop ends, the block can insert a stabilization delay before the CPU clock returns. Its length depends on the mode and is counted in source-oscillator ticks.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` reads 8'h40 (medium mode, main oscillator on, sub oscillator off, error clear), `state_o` is 0 (run), `main_osc_on_o` is 1 and `sub_osc_on_o` is 0.
- R2: `mode_o[7:6]` selects the divider. 00 is fast: one `phi_en_o` pulse every 2 main ticks. 01 is medium: one pulse every 8 main ticks. 10 is slow: one pulse every 2 sub ticks. 11 is reserved and can never be entered.
- R3: Only these writes to `wr_data_i[7:4]` are accepted:
  - any write that changes nothing;
  - in fast or medium mode, toggling bit 4 alone;
  - in fast or medium mode, toggling bit 6 alone;
  - a move to slow mode (10) from fast or medium mode, with bits 5:4 unchanged and bit 4 already 1;
  - in slow mode, toggling bit 5 alone.
- R4: Any other write leaves `mode_o[7:4]` unchanged and sets the error flag `mode_o[3]`.
- R5: The error flag stays set until an accepted write has `wr_data_i[3]`=1. If the same write is rejected, the flag stays set.
- R6: A move from slow mode to fast or medium mode (bit 7 cleared, bits 5:4 unchanged) is rejected unless bit 5 is 0 and the main oscillator has run for MAIN_STAB_TICKS ticks since it last started.
- R7: `main_osc_on_o` is the inverse of bit 5 and `sub_osc_on_o` follows bit 4. In stop (`state_o`=2), both are 0.
- R8: In run, `wait_req_i` enters wait (`state_o`=1). In wait, `phi_en_o` stays 0, `tmr_en_o` keeps pulsing, and `wake_i` returns to run in the same mode.
- R9: In run, `stop_req_i` enters stop; stop takes priority over wait. When `wake_i` arrives in stop with `dly_dis_i`=0, the block enters the delay state (`state_o`=3). It returns to run after a number of ticks that depends on the mode:
  - fast or medium mode: DLY_FAST_TICKS main ticks;
  - slow mode with `cnt_src_i`=1: DLY_SHORT_TICKS sub ticks;
  - slow mode with `cnt_src_i`=0: DLY_LONG_TICKS sub ticks.
- R10: When `wake_i` arrives in stop with `dly_dis_i`=1, the block returns to run on the next clock, with no delay.
- R11: Writes outside run are ignored, including error clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 8 | Write data: [7:4] mode, [3] error clear |
| main_tick_i | input | 1 | One pulse per main oscillator cycle |
| sub_tick_i | input | 1 | One pulse per sub oscillator cycle |
| stop_req_i | input | 1 | Request to enter stop |
| wait_req_i | input | 1 | Request to enter wait |
| wake_i | input | 1 | Wake event from stop or wait |
| dly_dis_i | input | 1 | 1 skips the stabilization delay on leaving stop |
| cnt_src_i | input | 1 | Picks the short (1) or long (0) delay in slow mode |
| mode_o | output | 8 | Register readback: [7:4] mode, [3] error, [2:0] zero |
| phi_en_o | output | 1 | Internal CPU clock enable pulse |
| tmr_en_o | output | 1 | Timer clock enable pulse, also active in wait |
| main_osc_on_o | output | 1 | Main oscillator running |
| sub_osc_on_o | output | 1 | Sub oscillator running |
| state_o | output | 2 | 0 run, 1 wait, 2 stop, 3 delay |

## Verification
A wrong mode register shows up in two ways at the ports. The `phi_en_o` pulse spacing changes within one divider period. A faulty rejection either leaves `mode_o[7:4]` unchanged or sets the error flag on the readback right after the write. Sequencing faults show in `state_o`. If the delay counter is loaded with the wrong value for the mode, the delay state ends early or late, so the bench samples `state_o` once before and once after the expected end of each delay length.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_STOP = 2'd2,
    ST_STAB = 2'd3
  } pwr_st_e;

  // bit order matches the register field [7:4]
  typedef struct packed {
    logic div_hi;
    logic div_lo;
    logic main_off;
    logic sub_on;
  } mode_t;

  localparam mode_t MODE_RST = '{div_hi: 1'b0, div_lo: 1'b1, main_off: 1'b0, sub_on: 1'b0};
endpackage

// File: rtl/sysclk_xition_chk.sv
`timescale 1ns/1ps
module sysclk_xition_chk
  import sysclk_pkg::*;
(
  input  mode_t cur_i,
  input  mode_t nxt_i,
  input  logic  main_rdy_i,
  output logic  legal_o
);
  logic [3:0] diff;

  always_comb begin
    diff    = cur_i ^ nxt_i;
    legal_o = 1'b0;
    if (diff == 4'b0000) begin
      legal_o = 1'b1;
    end else if (nxt_i.div_hi && nxt_i.div_lo) begin
      legal_o = 1'b0;
    end else if (!cur_i.div_hi) begin
      if (diff == 4'b0001 || diff == 4'b0100) legal_o = 1'b1;
      else if (nxt_i.div_hi && !nxt_i.div_lo && diff[1:0] == 2'b00)
        legal_o = cur_i.sub_on;
    end else begin
      if (diff == 4'b0010) legal_o = 1'b1;
      else if (!nxt_i.div_hi && diff[1:0] == 2'b00)
        legal_o = !cur_i.main_off && main_rdy_i;
    end
  end
endmodule

// File: rtl/sysclk_div.sv
`timescale 1ns/1ps
module sysclk_div #(
  parameter int unsigned SLOW_RATIO = 8,
  parameter int unsigned FAST_RATIO = 2,
  localparam int unsigned CW = $clog2(SLOW_RATIO)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_tick_i,
  input  logic ratio_slow_i,
  input  logic restart_i,
  output logic pulse_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = ratio_slow_i ? CW'(SLOW_RATIO - 1) : CW'(FAST_RATIO - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= src_tick_i && (cnt_q == lim);
      if (src_tick_i) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sysclk_wake_seq.sv
`timescale 1ns/1ps
module sysclk_wake_seq
  import sysclk_pkg::*;
#(
  parameter int unsigned DLY_FAST_TICKS  = 8192,
  parameter int unsigned DLY_LONG_TICKS  = 8192,
  parameter int unsigned DLY_SHORT_TICKS = 512,
  localparam int unsigned DMAX = (DLY_FAST_TICKS > DLY_LONG_TICKS) ? DLY_FAST_TICKS : DLY_LONG_TICKS,
  localparam int unsigned DW = $clog2(DMAX + 1)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stop_req_i,
  input  logic    wait_req_i,
  input  logic    wake_i,
  input  logic    dly_dis_i,
  input  logic    cnt_src_i,
  input  logic    low_mode_i,
  input  logic    main_tick_i,
  input  logic    sub_tick_i,
  output pwr_st_e state_o
);
  logic [DW-1:0] dcnt_q;
  logic [DW-1:0] load;
  logic          tk;

  assign load = !low_mode_i ? DW'(DLY_FAST_TICKS)
              : (cnt_src_i ? DW'(DLY_SHORT_TICKS) : DW'(DLY_LONG_TICKS));
  assign tk   = low_mode_i ? sub_tick_i : main_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_RUN;
      dcnt_q  <= '0;
    end else begin
      unique case (state_o)
        ST_RUN: begin
          if (stop_req_i)      state_o <= ST_STOP;
          else if (wait_req_i) state_o <= ST_WAIT;
        end
        ST_WAIT: if (wake_i) state_o <= ST_RUN;
        ST_STOP: begin
          if (wake_i) begin
            state_o <= dly_dis_i ? ST_RUN : ST_STAB;
            dcnt_q  <= load;
          end
        end
        ST_STAB: begin
          if (tk) begin
            if (dcnt_q <= DW'(1)) state_o <= ST_RUN;
            else                  dcnt_q  <= dcnt_q - DW'(1);
          end
        end
        default: state_o <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sysclk_mode_ctrl.sv
`timescale 1ns/1ps
module sysclk_mode_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned MAIN_STAB_TICKS = 1024,
  parameter int unsigned DLY_FAST_TICKS  = 8192,
  parameter int unsigned DLY_LONG_TICKS  = 8192,
  parameter int unsigned DLY_SHORT_TICKS = 512,
  localparam int unsigned SW = $clog2(MAIN_STAB_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       main_tick_i,
  input  logic       sub_tick_i,
  input  logic       stop_req_i,
  input  logic       wait_req_i,
  input  logic       wake_i,
  input  logic       dly_dis_i,
  input  logic       cnt_src_i,
  output logic [7:0] mode_o,
  output logic       phi_en_o,
  output logic       tmr_en_o,
  output logic       main_osc_on_o,
  output logic       sub_osc_on_o,
  output logic [1:0] state_o
);
  mode_t         mode_q;
  mode_t         nxt;
  logic          err_q;
  logic          legal;
  logic          wr_ok;
  logic          main_eff;
  logic          sub_eff;
  logic [SW-1:0] stab_q;
  logic          main_rdy;
  logic          div_pulse;
  pwr_st_e       st;

  assign nxt   = mode_t'(wr_data_i[7:4]);
  assign wr_ok = wr_en_i && (st == ST_RUN);

  sysclk_xition_chk i_chk (
    .cur_i     (mode_q),
    .nxt_i     (nxt),
    .main_rdy_i(main_rdy),
    .legal_o   (legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      err_q  <= 1'b0;
    end else if (wr_ok) begin
      if (legal) begin
        mode_q <= nxt;
        if (wr_data_i[3]) err_q <= 1'b0;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign main_osc_on_o = !mode_q.main_off && (st != ST_STOP);
  assign sub_osc_on_o  = mode_q.sub_on && (st != ST_STOP);
  assign main_eff      = main_tick_i && main_osc_on_o;
  assign sub_eff       = sub_tick_i && sub_osc_on_o;

  // main oscillator settle counter, restarts whenever the oscillator halts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          stab_q <= SW'(MAIN_STAB_TICKS);
    else if (!main_osc_on_o)                              stab_q <= '0;
    else if (main_eff && stab_q != SW'(MAIN_STAB_TICKS))  stab_q <= stab_q + SW'(1);
  end
  assign main_rdy = (stab_q == SW'(MAIN_STAB_TICKS));

  sysclk_div i_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_tick_i  (mode_q.div_hi ? sub_eff : main_eff),
    .ratio_slow_i(!mode_q.div_hi && mode_q.div_lo),
    .restart_i   (wr_ok && legal && (nxt != mode_q)),
    .pulse_o     (div_pulse)
  );

  sysclk_wake_seq #(
    .DLY_FAST_TICKS (DLY_FAST_TICKS),
    .DLY_LONG_TICKS (DLY_LONG_TICKS),
    .DLY_SHORT_TICKS(DLY_SHORT_TICKS)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req_i),
    .wait_req_i (wait_req_i),
    .wake_i     (wake_i),
    .dly_dis_i  (dly_dis_i),
    .cnt_src_i  (cnt_src_i),
    .low_mode_i (mode_q.div_hi),
    .main_tick_i(main_eff),
    .sub_tick_i (sub_eff),
    .state_o    (st)
  );

  assign phi_en_o = div_pulse && (st == ST_RUN);
  assign tmr_en_o = div_pulse && (st == ST_RUN || st == ST_WAIT);
  assign mode_o   = {mode_q, err_q, 3'b000};
  assign state_o  = st;
endmodule

// File: rtl/sysclk_mode_ctrl_sva.sv
`timescale 1ns/1ps
module sysclk_mode_ctrl_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] mode_o,
  input logic       phi_en_o,
  input logic       main_osc_on_o,
  input logic       sub_osc_on_o,
  input logic [1:0] state_o,
  input logic       legal,
  input logic       main_rdy
);
  a_r2_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[7:6] != 2'b11);

  a_r4_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_o == 2'd0 && !legal) |=> (mode_o[7:4] == $past(mode_o[7:4])) && mode_o[3]);

  a_r6_no_early_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && state_o == 2'd0 && mode_o[7] && !main_rdy) |=> mode_o[7]);

  a_r7_stop_osc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> (!main_osc_on_o && !sub_osc_on_o));

  a_r8_phi_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd0) |-> !phi_en_o);

  a_r9_stab_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3) |=> (state_o == 2'd3 || state_o == 2'd0));

  a_r11_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd0) |=> $stable(mode_o[7:3]));
endmodule

bind sysclk_mode_ctrl sysclk_mode_ctrl_sva i_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .mode_o       (mode_o),
  .phi_en_o     (phi_en_o),
  .main_osc_on_o(main_osc_on_o),
  .sub_osc_on_o (sub_osc_on_o),
  .state_o      (state_o),
  .legal        (legal),
  .main_rdy     (main_rdy)
);

// File: tb/test_sysclk_mode_ctrl.sv
`timescale 1ns/1ps
module test_sysclk_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       main_tick = 1'b0, sub_tick = 1'b0;
  logic       stop_req = 1'b0, wait_req = 1'b0, wake = 1'b0;
  logic       dly_dis = 1'b0, cnt_src = 1'b0;
  logic [7:0] mode;
  logic       phi_en, tmr_en, main_on, sub_on;
  logic [1:0] state;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct { string tag; int exp; } exp_t;
  exp_t exp_q[$];
  int   obs_q[$];

  always #4 clk = ~clk;

  sysclk_mode_ctrl #(
    .MAIN_STAB_TICKS(4), .DLY_FAST_TICKS(8), .DLY_LONG_TICKS(12), .DLY_SHORT_TICKS(3)
  ) i_sysclk_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .main_tick_i(main_tick), .sub_tick_i(sub_tick), .stop_req_i(stop_req),
    .wait_req_i(wait_req), .wake_i(wake), .dly_dis_i(dly_dis), .cnt_src_i(cnt_src),
    .mode_o(mode), .phi_en_o(phi_en), .tmr_en_o(tmr_en), .main_osc_on_o(main_on),
    .sub_osc_on_o(sub_on), .state_o(state)
  );

  // oscillator models: main every 2 clocks, sub every 16
  initial forever begin
    @(negedge clk);
    cyc++;
    main_tick = (cyc % 2 == 0);
    sub_tick  = (cyc % 16 == 0);
  end

  // driver side: expected item then observation
  task automatic expect_eq(string tag, int exp, int act);
    exp_t e;
    e.tag = tag; e.exp = exp;
    exp_q.push_back(e);
    obs_q.push_back(act);
  endtask

  // monitor: pops and compares
  initial forever begin
    exp_t e; int a;
    wait (obs_q.size() != 0);
    e = exp_q.pop_front();
    a = obs_q.pop_front();
    n_run++;
    if (a != e.exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, a, e.exp);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_in(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic interval(output int n);
    int g = 0;
    n = 0;
    do begin @(negedge clk); g++; end while (!phi_en && g < 400);
    do begin @(negedge clk); n++; end while (!phi_en && n < 400);
  endtask

  initial begin
    int n, np, nt;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_eq("R1 mode", 8'h40, mode);
    expect_eq("R1 state", 0, state);
    expect_eq("R1 main_on", 1, main_on);
    expect_eq("R1 sub_on", 0, sub_on);

    interval(n); expect_eq("R2 medium spacing", 16, n);
    wr(8'h80);   expect_eq("R4 to slow without sub", 8'h48, mode);
    wr(8'h48);   expect_eq("R5 clear flag", 8'h40, mode);
    wr(8'h00);   expect_eq("R3 medium to fast", 8'h00, mode);
    interval(n); expect_eq("R2 fast spacing", 4, n);
    wr(8'h20);   expect_eq("R4 bit5 in fast", 8'h08, mode);
    wr(8'h28);   expect_eq("R5 rejected write keeps flag", 8'h08, mode);
    wr(8'h08);   expect_eq("R5 clear flag", 8'h00, mode);
    wr(8'h10);   expect_eq("R3 sub on", 8'h10, mode);
    expect_eq("R7 sub_on", 1, sub_on);
    wr(8'h90);   expect_eq("R3 fast to slow", 8'h90, mode);
    interval(n); expect_eq("R2 slow spacing", 32, n);
    wr(8'hB0);   expect_eq("R3 stop main in slow", 8'hB0, mode);
    expect_eq("R7 main_on off", 0, main_on);
    wr(8'h10);   expect_eq("R4 slow to fast two bits", 8'hB8, mode);
    wr(8'hB8);   expect_eq("R5 clear", 8'hB0, mode);
    wr(8'h90);
    wr(8'h10);   expect_eq("R6 main not settled", 8'h98, mode);
    wr(8'h98);   expect_eq("R5 clear", 8'h90, mode);
    idle(20);
    wr(8'h10);   expect_eq("R6 main settled", 8'h10, mode);
    wr(8'hD0);   expect_eq("R2 reserved rejected", 8'h18, mode);
    wr(8'h18);   expect_eq("R5 clear", 8'h10, mode);
    wr(8'h50);   expect_eq("R3 fast to medium", 8'h50, mode);
    wr(8'h40);   expect_eq("R3 sub off in medium", 8'h40, mode);
    wr(8'h50);
    wr(8'h90);   expect_eq("R3 medium to slow", 8'h90, mode);
    wr(8'h10);   expect_eq("R3 slow to fast", 8'h10, mode);

    pulse_in(wait_req);
    expect_eq("R8 wait state", 1, state);
    np = 0; nt = 0;
    repeat (64) begin @(negedge clk); np += int'(phi_en); nt += int'(tmr_en); end
    expect_eq("R8 no phi in wait", 0, np);
    expect_eq("R8 timer runs", 1, int'(nt >= 10));
    wr(8'h00);   expect_eq("R11 write in wait ignored", 8'h10, mode);
    pulse_in(wake);
    expect_eq("R8 back to run", 0, state);
    interval(n); expect_eq("R8 same mode spacing", 4, n);

    dly_dis = 1'b0;
    pulse_in(stop_req);
    expect_eq("R9 stop state", 2, state);
    expect_eq("R7 main off in stop", 0, main_on);
    expect_eq("R7 sub off in stop", 0, sub_on);
    pulse_in(wake);
    expect_eq("R9 delay state fast", 3, state);
    idle(6);  expect_eq("R9 fast delay running", 3, state);
    idle(24); expect_eq("R9 fast delay done", 0, state);
    expect_eq("R9 mode kept", 8'h10, mode);

    wr(8'h90);
    cnt_src = 1'b1;
    pulse_in(stop_req);
    pulse_in(wake);
    idle(20); expect_eq("R9 short delay running", 3, state);
    idle(50); expect_eq("R9 short delay done", 0, state);

    cnt_src = 1'b0;
    pulse_in(stop_req);
    pulse_in(wake);
    idle(150); expect_eq("R9 long delay running", 3, state);
    idle(90);  expect_eq("R9 long delay done", 0, state);

    dly_dis = 1'b1;
    pulse_in(stop_req);
    @(negedge clk); wake = 1'b1; wr_en = 1'b1; wr_data = 8'hB0;
    @(negedge clk); wake = 1'b0; wr_en = 1'b0;
    expect_eq("R10 no delay", 0, state);
    expect_eq("R11 write in stop ignored", 8'h90, mode);

    idle(2);
    wait (obs_q.size() == 0);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule